// File: doc/BRIEF.md
# Shared-Bus Configuration Register Port

This block lets a host processor set up and inspect a bank of 10-bit control registers over one 10-bit parallel bus. The bus carries both the register address and the data. Chip select, read strobe and write strobe are all active low. The host writes twice in a row. The first write picks the register, and the second write fills it. After that the port expects an address again.

A read places the contents of the currently selected register on the bus and puts the sequence back to the address step. Reads are allowed only while the scan-activity input is low, so the port never competes with the pixel path for the bus. Writes are accepted at any time.

The bidirectional pin is split into a data output and an output enable. The whole bank is available as a flat parallel vector for the datapath. One decoded bit, bit 7 of register 9, selects the direction of the coefficient clock pins. Strobes are asynchronous to the master clock. They are resynchronised and take effect once, on their release.

Top module: `regbank_host_port`

## Requirements
- R1: While `rst_ni` is low, every register clears to zero, the latched address clears to 0 and the port returns to the address step. The whole of `regs_o` reads 0, and `bus_o` reads 0.
- R2: A write counts only if `cs_ni` is low when `wr_ni` is released (rises). A write strobe released with `cs_ni` high changes no register and does not advance the address/data sequence.
- R3: The first counted write in a sequence latches bus bits [4:0] as the register address. Bits [9:5] of that bus value are ignored.
- R4: The next counted write stores the full 10-bit bus value into the register at the latched address, shown at `regs_o[10*a +: 10]`. The port then expects an address again.
- R5: Writes are accepted and stored whatever the level of `scan_i`.
- R6: `bus_oe_o` is high exactly when `cs_ni`, `rd_ni` and `scan_i` are all low. While it is high, `bus_o` carries the register at the latched address.
- R7: `bus_o` is all zeros whenever `bus_oe_o` is low.
- R8: Releasing `rd_ni` while `cs_ni` is low returns the port to the address step. This holds even when `scan_i` is high and no data was driven.
- R9: `coef_clk_dir_o` equals bit 7 of register 9.
- R10: A strobe held low for many clock cycles counts as a single access.
- R11: A read changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| scan_i | input | 1 | Line-scan activity; high blocks reads |
| bus_i | input | 10 | Host bus, incoming value (bit 0 LSB) |
| bus_o | output | 10 | Host bus, outgoing value |
| bus_oe_o | output | 1 | Output enable for the host bus |
| regs_o | output | 320 | All 32 registers, register n at bits [10n+9:10n] |
| coef_clk_dir_o | output | 1 | Direction select for the coefficient clock pins |

## Verification
The main two-write sequence is tried with a table of address/data pairs that covers several kinds of values. These include all-ones and alternating-bit data, the lowest and highest register, a rewrite of the same register, and both values of the direction bit. These pairs separate a wrong register, a wrong data width, and a stale decode. Directed patterns then add four more kinds of access. An address with its upper bits set shows that those bits are dropped. A strobe released without chip select shows that the sequence does not move. A read made while scanning is active shows no drive, yet the sequence still returns to the address step. A strobe held low for a long time shows that it is counted only once.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned CFG_DATA_W   = 10;
  localparam int unsigned CFG_NUM_REGS = 32;
  localparam int unsigned CFG_DIR_REG  = 9;
  localparam int unsigned CFG_DIR_BIT  = 7;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/cfgp_sync_chain.sv
module cfgp_sync_chain #(
  parameter int unsigned       WIDTH   = 13,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgp_access_seq.sv
module cfgp_access_seq
  import cfgp_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              wr_s_i,
  input  logic              rd_s_i,
  input  logic [DATA_W-1:0] bus_s_i,
  output logic              wr_evt_o,
  output logic              rd_evt_o,
  output logic              store_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output phase_t            phase_o
);
  logic              wr_q, rd_q, cs_q;
  logic [DATA_W-1:0] bus_q;
  phase_t            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              store_d;

  // history of the synchronised pins, one cycle behind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b1;
      rd_q  <= 1'b1;
      cs_q  <= 1'b1;
      bus_q <= '0;
    end else begin
      wr_q  <= wr_s_i;
      rd_q  <= rd_s_i;
      cs_q  <= cs_s_i;
      bus_q <= bus_s_i;
    end
  end

  // a strobe acts on its release, qualified by select in the last low cycle
  assign wr_evt_o = wr_s_i & ~wr_q & ~cs_q;
  assign rd_evt_o = rd_s_i & ~rd_q & ~cs_q;

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    store_d = 1'b0;
    if (rd_evt_o) begin
      phase_d = PH_ADDR;
    end else if (wr_evt_o) begin
      if (phase_q == PH_ADDR) begin
        addr_d  = bus_q[ADDR_W-1:0];
        phase_d = PH_DATA;
      end else begin
        store_d = 1'b1;
        phase_d = PH_ADDR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ADDR;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
    end
  end

  assign store_o = store_d;
  assign wdata_o = bus_q;
  assign addr_o  = addr_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/cfgp_reg_array.sv
module cfgp_reg_array #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic en;
    assign en = we_i && (waddr_i == ADDR_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[r] <= '0;
      else if (en)  mem_q[r] <= wdata_i;
    end
    assign flat_o[r*DATA_W +: DATA_W] = mem_q[r];
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/regbank_host_port.sv
module regbank_host_port
  import cfgp_pkg::*;
#(
  parameter int unsigned DATA_W      = CFG_DATA_W,
  parameter int unsigned NUM_REGS    = CFG_NUM_REGS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIR_REG     = CFG_DIR_REG,
  parameter int unsigned DIR_BIT     = CFG_DIR_BIT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       rd_ni,
  input  logic                       wr_ni,
  input  logic                       scan_i,
  input  logic [DATA_W-1:0]          bus_i,
  output logic [DATA_W-1:0]          bus_o,
  output logic                       bus_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       coef_clk_dir_o
);
  localparam int unsigned ADDR_W = $clog2(NUM_REGS);
  localparam int unsigned SYNC_W = DATA_W + 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {DATA_W{1'b0}}};

  logic              rst_n_s;
  logic [SYNC_W-1:0] pins_s;
  logic              wr_evt, rd_evt, store;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  phase_t            phase;

  cfgp_rst_sync #(.STAGES(2)) i_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  cfgp_sync_chain #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .d_i   ({cs_ni, wr_ni, rd_ni, bus_i}),
    .q_o   (pins_s)
  );

  cfgp_access_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .cs_s_i  (pins_s[DATA_W+2]),
    .wr_s_i  (pins_s[DATA_W+1]),
    .rd_s_i  (pins_s[DATA_W]),
    .bus_s_i (pins_s[DATA_W-1:0]),
    .wr_evt_o(wr_evt),
    .rd_evt_o(rd_evt),
    .store_o (store),
    .addr_o  (addr),
    .wdata_o (wdata),
    .phase_o (phase)
  );

  cfgp_reg_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .we_i   (store),
    .waddr_i(addr),
    .wdata_i(wdata),
    .raddr_i(addr),
    .rdata_o(rdata),
    .flat_o (regs_o)
  );

  // drive only under the full read condition, straight from the pins
  assign bus_oe_o       = ~cs_ni & ~rd_ni & ~scan_i;
  assign bus_o          = bus_oe_o ? rdata : '0;
  assign coef_clk_dir_o = regs_o[DIR_REG*DATA_W + DIR_BIT];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DIR_REG  = 9,
  parameter int unsigned DIR_BIT  = 7
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       rst_n_s,
  input logic                       cs_ni,
  input logic                       rd_ni,
  input logic                       scan_i,
  input logic [DATA_W-1:0]          bus_o,
  input logic                       bus_oe_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic                       coef_clk_dir_o,
  input logic                       wr_evt,
  input logic                       rd_evt,
  input logic                       phase,
  input logic [ADDR_W-1:0]          addr
);
  assert_oe_needs_idle_scan_R6: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) bus_oe_o |-> (!scan_i && !cs_ni && !rd_ni));

  assert_read_shows_latched_R6: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) bus_oe_o |-> (bus_o == regs_o[addr*DATA_W +: DATA_W]));

  assert_quiet_bus_R7: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) !bus_oe_o |-> (bus_o == '0));

  assert_read_restarts_R8: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) rd_evt |=> (phase == 1'b0));

  assert_bank_holds_R11: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) !wr_evt |=> $stable(regs_o));

  assert_addr_step_keeps_bank_R3: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) (wr_evt && !rd_evt && phase == 1'b0) |=> ($stable(regs_o) && phase == 1'b1));

  assert_dir_only_on_write_R9: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_n_s) !wr_evt |=> $stable(coef_clk_dir_o));
endmodule

bind regbank_host_port cfgp_checker #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W),
  .DIR_REG (DIR_REG),
  .DIR_BIT (DIR_BIT)
) i_cfgp_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rst_n_s       (rst_n_s),
  .cs_ni         (cs_ni),
  .rd_ni         (rd_ni),
  .scan_i        (scan_i),
  .bus_o         (bus_o),
  .bus_oe_o      (bus_oe_o),
  .regs_o        (regs_o),
  .coef_clk_dir_o(coef_clk_dir_o),
  .wr_evt        (wr_evt),
  .rd_evt        (rd_evt),
  .phase         (phase),
  .addr          (addr)
);

// File: tb/test_regbank_host_port.sv
module test_regbank_host_port;
  localparam int DW = 10;
  localparam int NR = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni, cs_ni, rd_ni, wr_ni, scan_i;
  logic [DW-1:0] bus_i;
  logic [DW-1:0] bus_o;
  logic          bus_oe_o;
  logic [NR*DW-1:0] regs_o;
  logic          coef_clk_dir_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NR];

  always #2 clk_i = ~clk_i;

  regbank_host_port i_regbank_host_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .scan_i(scan_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .regs_o(regs_o), .coef_clk_dir_o(coef_clk_dir_o)
  );

  // {address word, data word}
  localparam logic [19:0] VECS [6] = '{
    {10'h000, 10'h3FF}, {10'h01F, 10'h155}, {10'h009, 10'h080},
    {10'h00A, 10'h2AA}, {10'h011, 10'h001}, {10'h009, 10'h07F}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_write(input logic [DW-1:0] v, input logic sel, input int hold);
    bus_i = v; cs_ni = sel; ticks(2);
    wr_ni = 1'b0; ticks(hold);
    wr_ni = 1'b1; ticks(3);
    cs_ni = 1'b1; ticks(5);
  endtask

  task automatic bus_read(output logic oe, output logic [DW-1:0] d);
    cs_ni = 1'b0; ticks(1);
    rd_ni = 1'b0; ticks(3);
    oe = bus_oe_o; d = bus_o;
    rd_ni = 1'b1; ticks(3);
    cs_ni = 1'b1; ticks(5);
  endtask

  task automatic store(input logic [DW-1:0] a, input logic [DW-1:0] d);
    bus_write(a, 1'b0, 3);
    bus_write(d, 1'b0, 3);
    model[a[4:0]] = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic oe;
    logic [DW-1:0] rd;
    rst_ni = 1'b0; cs_ni = 1'b1; rd_ni = 1'b1; wr_ni = 1'b1; scan_i = 1'b0; bus_i = '0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    ticks(8);
    // R1: reset state
    check("R1 regs zero", DW'(regs_o == '0), 10'd1);
    check("R1 bus_o", bus_o, '0);
    check("R1 oe", DW'(bus_oe_o), '0);
    check("R1 dir", DW'(coef_clk_dir_o), '0);
    rst_ni = 1'b1; ticks(6);

    // table walk: R4 store, R9 decode, R6 readback, R7 idle bus
    for (int v = 0; v < 6; v++) begin
      store(VECS[v][19:10], VECS[v][9:0]);
      check("R4 stored word", regs_o[VECS[v][14:10]*DW +: DW], VECS[v][9:0]);
      check("R9 dir bit", DW'(coef_clk_dir_o), DW'(model[9][7]));
      bus_write(VECS[v][19:10], 1'b0, 3);
      bus_read(oe, rd);
      check("R6 oe on read", DW'(oe), 10'd1);
      check("R6 read data", rd, model[VECS[v][14:10]]);
      check("R7 idle bus", bus_o, '0);
    end

    // R3: upper address bits dropped
    store(10'h3E5, 10'h123);
    check("R3 upper bits ignored", regs_o[5*DW +: DW], 10'h123);

    // R2: write released with select high does not count
    bus_write(10'h002, 1'b1, 3);
    store(10'h007, 10'h0CC);
    check("R2 target reg", regs_o[7*DW +: DW], 10'h0CC);
    check("R2 untouched reg", regs_o[2*DW +: DW], model[2]);

    // R5: writes while scanning
    scan_i = 1'b1;
    store(10'h00C, 10'h2B3);
    check("R5 write while scanning", regs_o[12*DW +: DW], 10'h2B3);

    // R8 with R6/R7: read while scanning drives nothing but restarts sequence
    bus_write(10'h003, 1'b0, 3);
    bus_read(oe, rd);
    check("R6 no drive while scanning", DW'(oe), '0);
    check("R7 zero while scanning", rd, '0);
    scan_i = 1'b0; ticks(2);
    store(10'h155, 10'h0AA);
    check("R8 new address after read", regs_o[21*DW +: DW], 10'h0AA);
    check("R8 old address untouched", regs_o[3*DW +: DW], model[3]);

    // R10: long strobe counted once
    bus_write(10'h00E, 1'b0, 50);
    bus_write(10'h111, 1'b0, 50);
    model[14] = 10'h111;
    check("R10 long strobes", regs_o[14*DW +: DW], 10'h111);

    // R11: nothing altered by all the reads
    for (int i = 0; i < NR; i++) check("R11 bank intact", regs_o[i*DW +: DW], model[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule